// File: doc/BRIEF.md
# Slotted Global I/O Bus Merger

This block joins the column-read outputs of eight half-bank sources onto one shared global I/O bus. The bus runs faster than the array. Each half-bank captures a 256-bit word into its own local latch when its load strobe pulses. The array rate is modelled as a load strobe that is active only once every 2 or 4 global cycles.

A loaded latch shows busy and asks for the bus. When a slot is free, a round-robin arbiter picks one waiting latch. That latch then sends its word as a short burst of narrower beats. The ratio is 2:1 (two 128-bit beats) or 4:1 (four 64-bit beats). Each beat carries the index of the source half-bank as a tag.

Since every latch holds its word until it gets a slot, several half-banks can be loaded one after another while the bus drains them at its own pace.

Top module: `gio_slot_merger`

## Requirements
- R1: After reset, every busy bit, `ovf`, `gio_valid`, `gio_data` and `gio_tag` are zero.
- R2: A load strobe on an idle source captures that source's 256-bit slice of `ld_data`, and its busy bit is high in the next cycle.
- R3: A load strobe on a source whose busy bit is high is rejected, and the latch keeps its old word. `ovf` is high in the cycle after the rejected strobe.
- R4: With `quad_mode` low (2:1), a word leaves as two 128-bit beats, bits [127:0] first and then bits [255:128].
- R5: With `quad_mode` high (4:1), a word leaves as four 64-bit beats, least significant first. Each beat is placed in `gio_data[63:0]` with bits [127:64] zero.
- R6: Every beat carries the index (0 to 7) of the source it came from on `gio_tag`.
- R7: On an idle bus, the first beat appears two cycles after the cycle in which the load strobe is high. The beats of one burst occupy back-to-back cycles.
- R8: When several sources wait, the arbiter searches upward, with wrap-around, starting from the source after the last one granted. After reset the search starts at source 0.
- R9: When another source is waiting, its first beat follows the previous burst's last beat in the very next cycle, with no empty slot.
- R10: A source's busy bit is low in the cycle after its last beat, and a load strobe in that cycle is accepted without `ovf`.
- R11: In a slot where no source transmits, `gio_valid` is low and both `gio_data` and `gio_tag` are zero.
- R12: The ratio of a burst is taken from `quad_mode` in the cycle in which the burst is granted. A change of `quad_mode` during the burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global I/O clock |
| rst_n | input | 1 | Active-low synchronous reset |
| quad_mode | input | 1 | 1 selects 4:1 serialization, 0 selects 2:1 |
| ld | input | 8 | Per-source load strobe |
| ld_data | input | 2048 | Source i word in bits [256*i+255 : 256*i] |
| busy | output | 8 | Per-source latch holds unsent data |
| ovf | output | 1 | A load hit a busy latch in the previous cycle |
| gio_valid | output | 1 | The current slot carries a beat |
| gio_data | output | 128 | Beat data |
| gio_tag | output | 3 | Source index of the current beat |

## Verification
The bench builds the block with its defaults of eight sources and 256-bit words. This gives a 3-bit tag, so the tag can take every value and the round-robin pointer wraps across the full source set. It also gives real 128-bit and 64-bit beat widths, so a lane-order mistake or a stray upper half in 4:1 mode shows up in the data.

A three-source simultaneous load checks both the grant order after a wrap and the gap-free handover between bursts. Separate sequences cover the reload in the release cycle, the overflow rejection and a mode change during a burst.

// File: rtl/gio_slot_merger.sv
module gio_slot_merger #(
  parameter int NSRC   = 8,
  parameter int WORD_W = 256,
  localparam int TAG_W  = $clog2(NSRC),
  localparam int HALF_W = WORD_W / 2,
  localparam int QTR_W  = WORD_W / 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     quad_mode,
  input  logic [NSRC-1:0]          ld,
  input  logic [NSRC*WORD_W-1:0]   ld_data,
  output logic [NSRC-1:0]          busy,
  output logic                     ovf,
  output logic                     gio_valid,
  output logic [HALF_W-1:0]        gio_data,
  output logic [TAG_W-1:0]         gio_tag
);

  logic [WORD_W-1:0] lat [NSRC];
  logic              act, q_cur;
  logic [1:0]        cnt;
  logic [TAG_W-1:0]  own, ptr, gnt_idx;
  logic              gnt_ok, last, free, take;
  logic [NSRC-1:0]   req;
  logic [WORD_W-1:0] cur;

  assign last = act && (cnt == (q_cur ? 2'd3 : 2'd1));
  assign free = !act || last;
  assign req  = busy & ~(act ? (NSRC'(1) << own) : '0);
  assign take = free && gnt_ok;

  always_comb begin
    gnt_ok  = 1'b0;
    gnt_idx = '0;
    for (int k = 0; k < NSRC; k++) begin
      int j;
      j = (int'(ptr) + k) % NSRC;
      if (!gnt_ok && req[j]) begin
        gnt_ok  = 1'b1;
        gnt_idx = TAG_W'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act   <= 1'b0;
      q_cur <= 1'b0;
      cnt   <= '0;
      own   <= '0;
      ptr   <= '0;
    end else if (take) begin
      act   <= 1'b1;
      own   <= gnt_idx;
      cnt   <= '0;
      q_cur <= quad_mode;
      ptr   <= (int'(gnt_idx) == NSRC - 1) ? '0 : gnt_idx + 1'b1;
    end else if (last) begin
      act <= 1'b0;
    end else if (act) begin
      cnt <= cnt + 1'b1;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy[i] <= 1'b0;
        lat[i]  <= '0;
      end else if (ld[i] && !busy[i]) begin
        busy[i] <= 1'b1;
        lat[i]  <= ld_data[i*WORD_W +: WORD_W];
      end else if (last && int'(own) == i) begin
        busy[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovf <= 1'b0;
    else        ovf <= |(ld & busy);
  end

  assign cur       = lat[own];
  assign gio_valid = act;
  assign gio_tag   = act ? own : '0;
  assign gio_data  = !act  ? '0 :
                     q_cur ? HALF_W'(cur[cnt*QTR_W +: QTR_W]) :
                             cur[cnt[0]*HALF_W +: HALF_W];

  assert_ovf_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ld & busy)) |=> ovf);

  assert_tag_owner_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gio_valid |-> busy[gio_tag]);

  assert_burst_contig_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gio_valid && !last) |=> (gio_valid && $stable(gio_tag)));

  assert_grant_requester_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> req[gnt_idx]);

  assert_no_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (last && |req) |=> gio_valid);

  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gio_valid && last) |=> !busy[$past(gio_tag)]);

  assert_quad_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gio_valid && q_cur) |-> (gio_data[HALF_W-1:QTR_W] == '0));

endmodule

// File: tb/gio_slot_merger_tb.sv
module gio_slot_merger_tb_top;
  localparam int N = 8, W = 256, H = W / 2, T = 3;

  logic clk = 0, rst_n = 0, quad_mode = 0;
  logic [N-1:0] ld = '0;
  logic [N*W-1:0] ld_data = '0;
  logic [N-1:0] busy;
  logic ovf, gio_valid;
  logic [H-1:0] gio_data;
  logic [T-1:0] gio_tag;

  int vectors = 0, fails = 0;
  logic [T+H-1:0] expq [$];

  gio_slot_merger dut_i (.clk(clk), .rst_n(rst_n), .quad_mode(quad_mode), .ld(ld),
    .ld_data(ld_data), .busy(busy), .ovf(ovf), .gio_valid(gio_valid),
    .gio_data(gio_data), .gio_tag(gio_tag));

  always #5 clk = ~clk;

  function automatic logic [W-1:0] mk(int s, int seed);
    logic [W-1:0] w;
    for (int l = 0; l < 8; l++) w[l*32 +: 32] = {8'(s), 8'(seed), 16'(l * 4369 + 1)};
    return w;
  endfunction

  task automatic chk(bit ok, string req, logic [H-1:0] act, logic [H-1:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_word(int s, int seed, bit quad);
    logic [W-1:0] w = mk(s, seed);
    if (quad) for (int b = 0; b < 4; b++) expq.push_back({T'(s), H'(w[b*64 +: 64])});
    else      for (int b = 0; b < 2; b++) expq.push_back({T'(s), w[b*H +: H]});
  endtask

  task automatic do_load(logic [N-1:0] m, int seed);
    for (int i = 0; i < N; i++) if (m[i]) ld_data[i*W +: W] = mk(i, seed);
    ld = m;
    @(posedge clk); #1;
    ld = '0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (gio_valid || busy != 0);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (gio_valid) begin
        if (expq.size() == 0) chk(0, "R6 unexpected beat", gio_data, '0);
        else begin
          logic [T+H-1:0] e;
          e = expq.pop_front();
          chk({gio_tag, gio_data} == e, "R4 R5 R6 R8 beat", gio_data, e[H-1:0]);
          if (gio_tag != e[T+H-1:H]) $display("  tag actual=%0d expected=%0d", gio_tag, e[T+H-1:H]);
        end
      end else begin
        chk(gio_data == '0 && gio_tag == '0, "R11 idle slot", gio_data, '0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && !ovf && !gio_valid && gio_data == 0, "R1 reset", H'(busy), '0);
    @(posedge clk); #1;

    // single source, 2:1, first-beat latency
    quad_mode = 0;
    push_word(3, 1, 0);
    do_load(8'h08, 1);
    @(negedge clk);
    chk(busy[3] == 1'b1, "R2 busy after load", H'(busy), H'(8'h08));
    chk(!gio_valid, "R7 no beat yet", H'(gio_valid), '0);
    @(negedge clk);
    chk(gio_valid, "R7 first beat latency", H'(gio_valid), 1);
    wait_idle();

    // three sources at once, 4:1, round-robin order 5,0,2, no gaps
    @(posedge clk); #1;
    quad_mode = 1;
    push_word(5, 2, 1); push_word(0, 2, 1); push_word(2, 2, 1);
    do_load(8'h25, 2);
    do @(negedge clk); while (!gio_valid);
    n = 0;
    while (gio_valid) begin n++; @(negedge clk); end
    chk(n == 12, "R9 back-to-back slots", H'(n), 12);
    wait_idle();

    // overflow: second load to a busy source is dropped
    @(posedge clk); #1;
    quad_mode = 0;
    push_word(1, 3, 0);
    do_load(8'h02, 3);
    do_load(8'h02, 4);
    @(negedge clk);
    chk(ovf, "R3 overflow flag", H'(ovf), 1);
    wait_idle();

    // reload in the release cycle
    @(posedge clk); #1;
    push_word(6, 5, 0);
    do_load(8'h40, 5);
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk(busy[6] && gio_valid, "R10 busy through last beat", H'(busy), H'(8'h40));
    @(posedge clk); #1;
    chk(busy[6] == 1'b0, "R10 busy clear after last beat", H'(busy), '0);
    push_word(6, 6, 0);
    do_load(8'h40, 6);
    @(negedge clk);
    chk(!ovf && busy[6], "R10 reload accepted", H'(ovf), '0);
    wait_idle();

    // ratio change during a burst has no effect
    @(posedge clk); #1;
    quad_mode = 0;
    push_word(4, 7, 0);
    do_load(8'h10, 7);
    @(posedge clk); #1;
    quad_mode = 1;
    wait_idle();
    quad_mode = 0;

    @(negedge clk);
    chk(expq.size() == 0, "R12 all beats seen", H'(expq.size()), '0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule